// File: doc/BRIEF.md
# Segmented Paged Address Translator

This unit turns a 32-bit virtual address into a physical address in two stages. The top four bits pick one of sixteen segments in an on-chip table. Each table entry holds a valid flag, a byte limit and the base address of that segment's own page table. The rest of the address is the offset within the segment. Its upper sixteen bits are the page number and its lower twelve bits are the offset inside the page.

When a request is accepted, the segment lookup and the limit comparison finish in that same cycle. A request that fails either check returns a fault on the next cycle and never reaches memory. A request that passes issues one read of the page table entry at `base + page*4`. When the entry arrives, the unit returns the frame number joined to the page offset, or a page fault if the entry is not valid. Only one translation is in flight at a time. Software loads the segment table through a write port that can be used at any time.

Top module: `segpage_xlate`

## Requirements
- R1: After reset, `rsp_valid` and `mem_req_valid` are low, `req_ready` is high, and every segment reads as invalid.
- R2: A translation that succeeds returns `rsp_fault` = 2'b00 and `rsp_paddr` = {PTE[31:12], vaddr[11:0]}. PTE bits [11:1] have no effect on the result.
- R3: A request that passes its checks drives `mem_req_valid` for exactly one cycle, one cycle after acceptance, with `mem_req_addr` = segment page-table base + vaddr[27:12]*4.
- R4: A request whose segment (vaddr[31:28]) is marked invalid returns `rsp_fault` = 2'b01 one cycle after acceptance and issues no memory read.
- R5: A request whose offset within the segment (vaddr[27:0]) is greater than or equal to the segment limit returns `rsp_fault` = 2'b10 one cycle after acceptance and issues no read. An offset of limit-1 is translated normally.
- R6: A fetched PTE with bit 0 clear returns `rsp_fault` = 2'b11 with `rsp_paddr` = 0.
- R7: A segment-table write is used by every request accepted after the write cycle. Each segment uses its own page-table base.
- R8: `req_ready` is low from the cycle after a read is issued until the response for that read is delivered.
- R9: `rsp_valid` rises exactly one cycle after `mem_rsp_valid` is seen for the outstanding read, and `req_ready` returns high in that same cycle.
- R10: The segment-invalid check takes priority over the limit check. An invalid segment with a zero limit reports 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Segment table write strobe |
| cfg_idx | input | 4 | Segment entry to write |
| cfg_limit | input | 28 | Segment length in bytes |
| cfg_ptbase | input | 32 | Page-table base address of the segment |
| cfg_valid | input | 1 | Segment-present flag to store |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address {segment, page, offset} |
| req_ready | output | 1 | Unit can accept a request |
| mem_req_valid | output | 1 | One-cycle PTE read strobe |
| mem_req_addr | output | 32 | PTE byte address |
| mem_rsp_valid | input | 1 | PTE data valid |
| mem_rsp_data | input | 32 | PTE word: bit 0 valid, bits [31:12] frame |
| rsp_valid | output | 1 | Result strobe |
| rsp_fault | output | 2 | 00 none, 01 segment, 10 limit, 11 page |
| rsp_paddr | output | 32 | Physical address; zero on a fault |

## Verification
The assertions assume that memory raises `mem_rsp_valid` only while a read is outstanding, and only once per read. They also assume that `req_valid` is sampled only when `req_ready` is high. The bench's memory model answers each read exactly once after a fixed latency. Requests are sent only when the unit is idle. Segment-table writes are kept in cycles apart from request acceptance, so no lookup races a write to the same entry.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_SEG   = 2'b01,
    FLT_LIMIT = 2'b10,
    FLT_PAGE  = 2'b11
  } fault_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } xstate_e;

endpackage

// File: rtl/xlate_segtab.sv
module xlate_segtab #(
  parameter int SEG_W = 4,
  parameter int LIM_W = 28,
  parameter int PA_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_idx,
  input  logic [LIM_W-1:0] wr_limit,
  input  logic [PA_W-1:0]  wr_base,
  input  logic             wr_valid,
  input  logic [SEG_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [LIM_W-1:0] rd_limit,
  output logic [PA_W-1:0]  rd_base
);

  localparam int NSEG = 1 << SEG_W;

  // Limits and bases live in RAM without reset; presence bits are flops.
  logic [LIM_W-1:0] lim_mem  [NSEG];
  logic [PA_W-1:0]  base_mem [NSEG];
  logic [NSEG-1:0]  present_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      lim_mem[wr_idx]  <= wr_limit;
      base_mem[wr_idx] <= wr_base;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      present_q <= '0;
    end else if (wr_en) begin
      present_q[wr_idx] <= wr_valid;
    end
  end

  // Asynchronous read so that the check completes in the acceptance cycle.
  assign rd_valid = present_q[rd_idx];
  assign rd_limit = lim_mem[rd_idx];
  assign rd_base  = base_mem[rd_idx];

  // R1: every entry is absent right after reset
  p_clear_after_reset_r1: assert property (@(posedge clk)
    rst |=> (present_q == '0));

endmodule

// File: rtl/xlate_check.sv
module xlate_check
  import xlate_pkg::*;
#(
  parameter int PAGE_W  = 16,
  parameter int OFF_W   = 12,
  parameter int PA_W    = 32,
  parameter int PTE_LG2 = 2
) (
  input  logic [PAGE_W-1:0]       page,
  input  logic [OFF_W-1:0]        page_off,
  input  logic                    seg_present,
  input  logic [PAGE_W+OFF_W-1:0] seg_limit,
  input  logic [PA_W-1:0]         seg_base,
  output fault_e                  fault,
  output logic [PA_W-1:0]         pte_addr
);

  localparam int SOFF_W = PAGE_W + OFF_W;

  logic [SOFF_W-1:0] seg_off;
  logic              over_limit;

  assign seg_off    = {page, page_off};
  assign over_limit = (seg_off >= seg_limit);

  // The presence check outranks the limit check (R10).
  always_comb begin
    if (!seg_present) begin
      fault = FLT_SEG;
    end else if (over_limit) begin
      fault = FLT_LIMIT;
    end else begin
      fault = FLT_NONE;
    end
  end

  // The entry address is the segment's base plus the page index scaled to PTE size.
  assign pte_addr = seg_base + (PA_W'(page) << PTE_LG2);

endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
#(
  parameter int OFF_W = 12,
  parameter int PA_W  = 32,
  parameter int PTE_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [OFF_W-1:0] req_off,
  input  fault_e           chk_fault,
  input  logic [PA_W-1:0]  chk_pte_addr,
  output logic             mem_req_valid,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             rsp_valid,
  output fault_e           rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr
);

  localparam int FRAME_W   = PA_W - OFF_W;
  localparam int FRAME_LSB = PTE_W - FRAME_W;

  xstate_e          state_q;
  logic [OFF_W-1:0] off_q;
  logic             accept;
  logic             pte_ok;
  logic [FRAME_W-1:0] pte_frame;
  logic             unused_pte_bits;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign pte_ok    = mem_rsp_data[0];
  assign pte_frame = mem_rsp_data[PTE_W-1:FRAME_LSB];
  assign unused_pte_bits = ^mem_rsp_data[FRAME_LSB-1:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      off_q         <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      rsp_valid     <= 1'b0;
      rsp_fault     <= FLT_NONE;
      rsp_paddr     <= '0;
    end else begin
      mem_req_valid <= 1'b0;
      rsp_valid     <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (chk_fault != FLT_NONE) begin
              rsp_valid <= 1'b1;
              rsp_fault <= chk_fault;
              rsp_paddr <= '0;
            end else begin
              mem_req_valid <= 1'b1;
              mem_req_addr  <= chk_pte_addr;
              off_q         <= req_off;
              state_q       <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            rsp_valid <= 1'b1;
            state_q   <= ST_IDLE;
            if (pte_ok) begin
              rsp_fault <= FLT_NONE;
              rsp_paddr <= {pte_frame, off_q};
            end else begin
              rsp_fault <= FLT_PAGE;
              rsp_paddr <= '0;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4, R5: a failed check answers at once and never reads memory
  p_fault_no_read_r5: assert property (@(posedge clk) disable iff (rst)
    (accept && chk_fault != FLT_NONE) |=>
      (rsp_valid && !mem_req_valid && rsp_fault == $past(chk_fault)));

  // R3: a passing request issues its PTE read on the next cycle
  p_read_on_pass_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && chk_fault == FLT_NONE) |=>
      (mem_req_valid && mem_req_addr == $past(chk_pte_addr) && !rsp_valid));

  // R3: the read strobe lasts one cycle
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);

  // R8: stay busy until memory answers
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && !mem_rsp_valid) |=> (!req_ready && !rsp_valid));

  // R9: response follows the memory answer by one cycle
  p_rsp_follows_mem_r9: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && mem_rsp_valid) |=> (rsp_valid && req_ready));

  // R6: a page fault carries a zero address
  p_page_fault_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault == FLT_PAGE) |-> (rsp_paddr == '0));

endmodule

// File: rtl/segpage_xlate.sv
module segpage_xlate
  import xlate_pkg::*;
#(
  parameter int SEG_W   = 4,
  parameter int PAGE_W  = 16,
  parameter int OFF_W   = 12,
  parameter int PA_W    = 32,
  parameter int PTE_W   = 32,
  parameter int PTE_LG2 = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_we,
  input  logic [SEG_W-1:0]              cfg_idx,
  input  logic [PAGE_W+OFF_W-1:0]       cfg_limit,
  input  logic [PA_W-1:0]               cfg_ptbase,
  input  logic                          cfg_valid,
  input  logic                          req_valid,
  input  logic [SEG_W+PAGE_W+OFF_W-1:0] req_vaddr,
  output logic                          req_ready,
  output logic                          mem_req_valid,
  output logic [PA_W-1:0]               mem_req_addr,
  input  logic                          mem_rsp_valid,
  input  logic [PTE_W-1:0]              mem_rsp_data,
  output logic                          rsp_valid,
  output logic [1:0]                    rsp_fault,
  output logic [PA_W-1:0]               rsp_paddr
);

  localparam int LIM_W = PAGE_W + OFF_W;
  localparam int VA_W  = SEG_W + LIM_W;

  logic [SEG_W-1:0]  va_seg;
  logic [PAGE_W-1:0] va_page;
  logic [OFF_W-1:0]  va_off;

  assign va_seg  = req_vaddr[VA_W-1 -: SEG_W];
  assign va_page = req_vaddr[LIM_W-1 -: PAGE_W];
  assign va_off  = req_vaddr[OFF_W-1:0];

  logic             st_present;
  logic [LIM_W-1:0] st_limit;
  logic [PA_W-1:0]  st_base;
  fault_e           chk_fault;
  logic [PA_W-1:0]  chk_pte_addr;
  fault_e           out_fault;

  xlate_segtab #(.SEG_W(SEG_W), .LIM_W(LIM_W), .PA_W(PA_W)) u_segtab (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_we),
    .wr_idx   (cfg_idx),
    .wr_limit (cfg_limit),
    .wr_base  (cfg_ptbase),
    .wr_valid (cfg_valid),
    .rd_idx   (va_seg),
    .rd_valid (st_present),
    .rd_limit (st_limit),
    .rd_base  (st_base)
  );

  xlate_check #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .PA_W(PA_W), .PTE_LG2(PTE_LG2)) u_check (
    .page        (va_page),
    .page_off    (va_off),
    .seg_present (st_present),
    .seg_limit   (st_limit),
    .seg_base    (st_base),
    .fault       (chk_fault),
    .pte_addr    (chk_pte_addr)
  );

  xlate_ctrl #(.OFF_W(OFF_W), .PA_W(PA_W), .PTE_W(PTE_W)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_off       (va_off),
    .chk_fault     (chk_fault),
    .chk_pte_addr  (chk_pte_addr),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (out_fault),
    .rsp_paddr     (rsp_paddr)
  );

  assign rsp_fault = out_fault;

  // R10: an absent segment is reported as such whatever its limit
  p_seg_priority_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !st_present) |=> (rsp_valid && rsp_fault == 2'b01));

endmodule

// File: tb/segpage_xlate_test.sv
`timescale 1ns/1ps
module segpage_xlate_test;

  localparam int LAT = 3;
  localparam int NV  = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [27:0] cfg_limit = '0;
  logic [31:0] cfg_ptbase = '0;
  logic        cfg_valid = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_fault;
  logic [31:0] rsp_paddr;

  always #2.5 clk = ~clk;

  segpage_xlate uut (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_limit(cfg_limit),
    .cfg_ptbase(cfg_ptbase), .cfg_valid(cfg_valid),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int reads = 0;
  int t_mem = 0;
  int cd = 0;
  logic [31:0] last_addr = '0;
  logic [31:0] tb_base [16];
  logic [27:0] tb_lim  [16];
  logic        tb_ok   [16];

  // PTE content model: low bits carry junk; page index low byte 0xEE is invalid.
  function automatic logic [31:0] pte_of(input logic [31:0] a);
    logic [19:0] fr;
    fr = a[21:2] ^ 20'hA5A5A;
    return {fr, 11'h2AA, (a[9:2] != 8'hEE)};
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid) begin
      last_addr <= mem_req_addr;
      reads     <= reads + 1;
      cd        <= LAT;
    end else if (cd > 0) begin
      cd <= cd - 1;
      if (cd == 1) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= pte_of(last_addr);
      end
    end
  end

  always @(negedge clk) if (mem_rsp_valid) t_mem = cyc;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) if (cyc >= 20000) begin
    errors++;
    $display("FAIL watchdog actual=%0d expected=<20000", cyc);
    summary();
  end

  task automatic seg_write(input int idx, input logic [27:0] lim, input logic [31:0] base, input bit ok);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_limit = lim; cfg_ptbase = base; cfg_valid = ok;
    tb_base[idx] = base; tb_lim[idx] = lim; tb_ok[idx] = ok;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Issue one request when idle; return fault, address, wait cycles, busy flag.
  task automatic xlate(input logic [31:0] va, output logic [1:0] f, output logic [31:0] pa,
                       output int waited, output bit busy_ok);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    waited  = 0;
    busy_ok = 1'b1;
    while (!rsp_valid && waited < 100) begin
      if (req_ready) busy_ok = 1'b0;
      @(negedge clk);
      waited++;
    end
    f  = rsp_fault;
    pa = rsp_paddr;
  endtask

  // {expected fault, vaddr}
  localparam logic [33:0] VEC [NV] = '{
    {2'b00, 32'h0000_0123},   // R2 seg0 page0
    {2'b00, 32'h0000_FFFF},   // R5 limit-1 passes
    {2'b10, 32'h0001_0000},   // R5 equal to limit
    {2'b00, 32'h1234_5678},   // R2 seg1
    {2'b11, 32'h100E_E010},   // R6 invalid PTE
    {2'b01, 32'h2000_0000},   // R10 invalid seg, zero limit
    {2'b10, 32'h3000_0000},   // R5 zero limit
    {2'b00, 32'h5000_0FFF},   // R5 last byte of one-page segment
    {2'b10, 32'h5000_1000},   // R5 one past
    {2'b01, 32'hF000_0000},   // R1 R4 never written
    {2'b10, 32'h1FFF_FFFF},   // R5 max offset equals limit
    {2'b00, 32'h1000_0ABC}    // R2 seg1 page0
  };

  initial begin
    logic [1:0]  f;
    logic [31:0] pa, ea, epa;
    int w, rb;
    bit busy;
    for (int i = 0; i < 16; i++) begin tb_base[i] = '0; tb_lim[i] = '0; tb_ok[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 0);
    check(mem_req_valid == 1'b0, "R1 mem_req_valid", 32'(mem_req_valid), 0);
    check(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 1);

    seg_write(0, 28'h001_0000, 32'h0010_0000, 1'b1);
    seg_write(1, 28'hFFF_FFFF, 32'h0020_0000, 1'b1);
    seg_write(2, 28'h000_0000, 32'h0060_0000, 1'b0);
    seg_write(3, 28'h000_0000, 32'h0030_0000, 1'b1);
    seg_write(5, 28'h000_1000, 32'h0040_0000, 1'b1);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] va;
      logic [1:0]  ef;
      va = VEC[i][31:0];
      ef = VEC[i][33:32];
      rb = reads;
      xlate(va, f, pa, w, busy);
      check(f == ef, $sformatf("R2/R4/R5/R6 fault vec%0d", i), 32'(f), 32'(ef));
      if (ef == 2'b00 || ef == 2'b11) begin
        ea  = tb_base[va[31:28]] + {14'd0, va[27:12], 2'b00};
        epa = (ef == 2'b00) ? {pte_of(ea)[31:12], va[11:0]} : 32'h0;
        check(last_addr == ea, $sformatf("R3 pte addr vec%0d", i), last_addr, ea);
        check(reads == rb + 1, $sformatf("R3 one read vec%0d", i), 32'(reads - rb), 1);
        check(pa == epa, $sformatf("R2 R6 paddr vec%0d", i), pa, epa);
        check(busy, $sformatf("R8 busy vec%0d", i), 32'(busy), 1);
        check(cyc - t_mem == 1, $sformatf("R9 latency vec%0d", i), 32'(cyc - t_mem), 1);
        check(req_ready == 1'b1, $sformatf("R9 ready vec%0d", i), 32'(req_ready), 1);
      end else begin
        check(reads == rb, $sformatf("R4 R5 no read vec%0d", i), 32'(reads - rb), 0);
        check(w == 0, $sformatf("R4 R5 immediate vec%0d", i), 32'(w), 0);
        check(pa == 32'h0, $sformatf("R5 zero paddr vec%0d", i), pa, 0);
      end
      repeat (LAT + 2) @(negedge clk);
    end

    // R7: new base for segment 5 is used by the next request
    seg_write(5, 28'h000_1000, 32'h0050_0000, 1'b1);
    xlate(32'h5000_0ABC, f, pa, w, busy);
    ea = 32'h0050_0000;
    check(last_addr == ea, "R7 new base", last_addr, ea);
    check(pa == {pte_of(ea)[31:12], 12'hABC}, "R7 new frame", pa, {pte_of(ea)[31:12], 12'hABC});
    // R7: clearing presence turns the same address into a segment fault
    seg_write(5, 28'h000_1000, 32'h0050_0000, 1'b0);
    xlate(32'h5000_0ABC, f, pa, w, busy);
    check(f == 2'b01, "R7 R4 cleared seg", 32'(f), 1);
    // R10: raise segment 2 to valid with zero limit -> limit fault instead
    seg_write(2, 28'h000_0000, 32'h0060_0000, 1'b1);
    xlate(32'h2000_0000, f, pa, w, busy);
    check(f == 2'b10, "R10 R5 valid zero limit", 32'(f), 2);

    // R1: reset again clears segment presence
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    xlate(32'h1000_0000, f, pa, w, busy);
    check(f == 2'b01, "R1 seg cleared by reset", 32'(f), 1);

    summary();
  end

endmodule